// File: doc/BRIEF.md
# Ancillary Packet FIFO with Message Tracking

This block buffers ancillary data packets between a packet extractor and a host that drains them over a parallel read port. The extractor presents one word per cycle with a start mark, an end mark and, on the start word, the length the packet header declares. The host pulls words one at a time. A word becomes readable only after its packet has been closed with an end mark, so the host never sees part of a packet that may still be withdrawn.

With tracking switched on, a small ring table records where each stored complete packet ends (eight at most). Before a packet is admitted, its declared length is weighed against the free space, and packets that would not fit are refused whole. The table also lets the host discard only the oldest stored packet. A self-clearing whole-FIFO flush is available as well. A complete-packet indicator, an early-warning flag at 90 percent fill, and sticky overrun, empty and full flags give the host what it needs to pace its reads. All storage operations are held off until a three-stage enable pipeline fed from the enable input has filled.

Top module: `anc_pkt_fifo`

## Requirements
- R1: After reset the enable pipeline is clear. A change on `fifo_clk_en` takes effect at the fourth rising edge after it is applied. While the pipeline output is low, writes, reads and flush requests have no effect and `rd_valid` stays low.
- R2: A read request on a non-empty FIFO returns the oldest unread word on `rd_data`, with `rd_valid` high, after the next rising edge. Words come out in the order they were written.
- R3: `empty` is high unless at least one word of a closed packet is unread. Words of a packet whose end mark has not been written cannot be read.
- R4: `msg_avail` is high exactly when at least one packet whose end-marked word was stored is still unread, with tracking on or off.
- R5: With tracking on, a start word whose declared length exceeds DEPTH minus the words held (unread words plus the open packet) is refused. The words up to its end mark are discarded and `overrun` is set.
- R6: With tracking on, a new packet is refused in the same way while eight complete packets are already tracked.
- R7: With tracking off, more than eight packets may be stored. A word that arrives while the FIFO holds DEPTH words is dropped and sets `overrun`.
- R8: `full` is high at DEPTH words held. `almost_full` is high at ceil(0.9 x DEPTH) words or more (231 for 256).
- R9: `wr_abort` discards every word of the open packet and returns its space.
- R10: A whole-FIFO flush request is taken in a cycle with no read and no write while tracking is on. `fifo_flush_busy` is then high for one cycle, during which the FIFO empties and `overrun` is cleared.
- R11: A whole-FIFO flush request made together with a read or a write, or with tracking off, is ignored.
- R12: A message flush request is latched in `msg_flush_busy` until a cycle with no read, write or abort. In that cycle it removes the oldest complete packet (tracking on only) and clears itself.
- R13: `overrun` stays set until reset or a whole-FIFO flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_clk_en | input | 1 | Storage enable, taken through a three-stage pipeline |
| track_en | input | 1 | Packet tracking enable |
| wr_valid | input | 1 | Write word present |
| wr_sop | input | 1 | Word is the first of a packet |
| wr_eop | input | 1 | Word is the last of a packet |
| wr_abort | input | 1 | Discard the open packet |
| wr_len | input | 9 | Declared packet length in words, sampled with the start word |
| wr_data | input | 10 | Write word |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 10 | Read word |
| fifo_flush_req | input | 1 | Whole-FIFO flush request pulse |
| msg_flush_req | input | 1 | Oldest-packet flush request pulse |
| fifo_flush_busy | output | 1 | Whole-FIFO flush in progress |
| msg_flush_busy | output | 1 | Oldest-packet flush pending |
| empty | output | 1 | No readable word |
| full | output | 1 | DEPTH words held |
| almost_full | output | 1 | Fill at or above the 90 percent mark |
| overrun | output | 1 | Sticky: data was refused or dropped |
| msg_avail | output | 1 | At least one complete packet stored |

## Verification
The hardest state to reach is the table-full refusal. It needs eight packets admitted with no read in between while the fill stays under the length check, so that the ninth start word is refused by the slot limit and not by free space. A directed sequence writes eight 30-word packets without reading, then offers a short packet that the space check alone would admit. The deferred message flush is forced by raising its request in the middle of a packet transfer. Around these directed cases, long random runs mix packet lengths, reads, aborts and flush requests against a reference queue model in the bench.

// File: rtl/anc_fifo_pkg.sv
package anc_fifo_pkg;

    typedef enum logic [1:0] {
        WP_IDLE = 2'd0,
        WP_OPEN = 2'd1,
        WP_DROP = 2'd2
    } wphase_e;

    // smallest count that reaches pct percent of depth
    function automatic int ceil_pct(input int depth, input int pct);
        return (depth * pct + 99) / 100;
    endfunction

endpackage

// File: rtl/anc_en_pipe.sv
module anc_en_pipe #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic active
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], en_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign active = sh_q[STAGES-1];

    // R1: a fresh enable never acts at the very next edge
    a_r1_enable_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_in) |=> !active);

endmodule

// File: rtl/anc_msg_table.sv
module anc_msg_table #(
    parameter int SLOTS = 8,
    parameter int PTR_W = 9,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [PTR_W-1:0] push_ptr,
    input  logic             pop,
    output logic [PTR_W-1:0] head_ptr,
    output logic [CNT_W-1:0] count,
    output logic             tab_full
);
    logic [PTR_W-1:0] ent_d [SLOTS];
    logic [PTR_W-1:0] ent_q [SLOTS];
    logic [IDX_W-1:0] hd_d, hd_q, tl_d, tl_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(SLOTS - 1)) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        ent_d = ent_q;
        hd_d  = hd_q;
        tl_d  = tl_q;
        cnt_d = cnt_q;
        if (clear) begin
            hd_d  = '0;
            tl_d  = '0;
            cnt_d = '0;
        end else begin
            if (push) begin
                ent_d[tl_q] = push_ptr;
                tl_d        = nxt(tl_q);
            end
            if (pop) hd_d = nxt(hd_q);
            if (push && !pop)      cnt_d = cnt_q + 1'b1;
            else if (pop && !push) cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_q  <= '0;
            tl_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < SLOTS; i++) ent_q[i] <= '0;
        end else begin
            hd_q  <= hd_d;
            tl_q  <= tl_d;
            cnt_q <= cnt_d;
            ent_q <= ent_d;
        end
    end

    assign head_ptr = ent_q[hd_q];
    assign count    = cnt_q;
    assign tab_full = (cnt_q == CNT_W'(SLOTS));

    // R6: never more entries than slots
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SLOTS));
    // R6: a packet is only recorded when a slot is free
    a_r6_push_room: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |-> (!tab_full || pop));
    // R12: popping an empty table must not happen
    a_r12_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |-> (cnt_q != '0));

endmodule

// File: rtl/anc_word_store.sv
module anc_word_store #(
    parameter int WORD_W = 11,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/anc_pkt_fifo.sv
module anc_pkt_fifo
    import anc_fifo_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int DEPTH     = 256,
    parameter int SLOTS     = 8,
    parameter int EN_STAGES = 3,
    parameter int WARN_PCT  = 90,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = AW + 1,
    localparam int TCW      = $clog2(SLOTS + 1),
    localparam int THR      = ceil_pct(DEPTH, WARN_PCT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_clk_en,
    input  logic              track_en,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              wr_abort,
    input  logic [PW-1:0]     wr_len,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fifo_flush_req,
    input  logic              msg_flush_req,
    output logic              fifo_flush_busy,
    output logic              msg_flush_busy,
    output logic              empty,
    output logic              full,
    output logic              almost_full,
    output logic              overrun,
    output logic              msg_avail
);
    typedef struct packed {
        logic [PW-1:0]     wr;
        logic [PW-1:0]     cm;
        logic [PW-1:0]     rd;
        logic [PW-1:0]     st;
        logic [PW-1:0]     cplt;
        logic              ovr;
        logic              ffp;
        logic              mfp;
        logic              rv;
        logic [DATA_W-1:0] rdat;
        wphase_e           ph;
    } state_t;

    state_t s_d, s_q;

    logic              active;
    logic [PW-1:0]     used, base, used_b;
    logic              full_w, empty_w, wrote, mreq;
    logic              we;
    logic [AW-1:0]     waddr;
    logic [DATA_W:0]   rword;
    logic              tab_push, tab_pop, tab_clr, tab_full;
    logic [PW-1:0]     tab_pptr, tab_head;
    logic [TCW-1:0]    tab_cnt;

    anc_en_pipe #(.STAGES(EN_STAGES)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_in  (fifo_clk_en),
        .active (active)
    );

    anc_msg_table #(.SLOTS(SLOTS), .PTR_W(PW)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tab_clr),
        .push     (tab_push),
        .push_ptr (tab_pptr),
        .pop      (tab_pop),
        .head_ptr (tab_head),
        .count    (tab_cnt),
        .tab_full (tab_full)
    );

    anc_word_store #(.WORD_W(DATA_W + 1), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata ({wr_eop, wr_data}),
        .raddr (s_q.rd[AW-1:0]),
        .rdata (rword)
    );

    assign used    = s_q.wr - s_q.rd;
    assign full_w  = (used == PW'(DEPTH));
    assign empty_w = (s_q.cm == s_q.rd);

    always_comb begin
        s_d      = s_q;
        s_d.rv   = 1'b0;
        we       = 1'b0;
        waddr    = s_q.wr[AW-1:0];
        tab_push = 1'b0;
        tab_pop  = 1'b0;
        tab_clr  = 1'b0;
        tab_pptr = '0;
        base     = s_q.wr;
        used_b   = '0;
        wrote    = 1'b0;
        mreq     = 1'b0;
        if (active) begin
            if (s_q.ffp) begin
                // whole-FIFO flush: everything back to the empty state
                s_d.wr   = '0;
                s_d.cm   = '0;
                s_d.rd   = '0;
                s_d.st   = '0;
                s_d.cplt = '0;
                s_d.ovr  = 1'b0;
                s_d.ffp  = 1'b0;
                s_d.mfp  = 1'b0;
                s_d.ph   = WP_IDLE;
                tab_clr  = 1'b1;
            end else begin
                // read side
                if (rd_en && !empty_w) begin
                    s_d.rd   = s_q.rd + 1'b1;
                    s_d.rv   = 1'b1;
                    s_d.rdat = rword[DATA_W-1:0];
                    if (rword[DATA_W]) begin
                        if (s_d.cplt != '0) s_d.cplt = s_d.cplt - 1'b1;
                        if (track_en && tab_cnt != '0) tab_pop = 1'b1;
                    end
                end
                // write side
                if (wr_abort) begin
                    if (s_q.ph == WP_OPEN) s_d.wr = s_q.st;
                    s_d.ph = WP_IDLE;
                end else if (wr_valid) begin
                    base   = (s_q.ph == WP_OPEN) ? s_q.st : s_q.wr;
                    used_b = base - s_q.rd;
                    if (wr_sop) begin
                        s_d.wr = base;
                        s_d.st = base;
                        if (track_en && (tab_full || wr_len > PW'(DEPTH) - used_b)) begin
                            s_d.ovr = 1'b1;
                            s_d.ph  = wr_eop ? WP_IDLE : WP_DROP;
                        end else begin
                            s_d.ph = WP_OPEN;
                            if (used_b != PW'(DEPTH)) begin
                                we     = 1'b1;
                                waddr  = base[AW-1:0];
                                s_d.wr = base + 1'b1;
                                wrote  = 1'b1;
                            end else begin
                                s_d.ovr = 1'b1;
                            end
                        end
                    end else if (s_q.ph == WP_OPEN) begin
                        if (!full_w) begin
                            we     = 1'b1;
                            s_d.wr = s_q.wr + 1'b1;
                            wrote  = 1'b1;
                        end else begin
                            s_d.ovr = 1'b1;
                        end
                    end else if (wr_eop) begin
                        s_d.ph = WP_IDLE;
                    end
                    if (s_d.ph == WP_OPEN && wr_eop) begin
                        s_d.ph = WP_IDLE;
                        s_d.cm = s_d.wr;
                        if (wrote) s_d.cplt = s_d.cplt + 1'b1;
                        if (track_en) begin
                            tab_push = 1'b1;
                            tab_pptr = s_d.wr;
                        end
                    end
                end
                // oldest-message flush, waits for an idle port cycle
                mreq = s_q.mfp | msg_flush_req;
                if (mreq && !wr_valid && !rd_en && !wr_abort) begin
                    s_d.mfp = 1'b0;
                    if (track_en && tab_cnt != '0) begin
                        s_d.rd  = tab_head;
                        tab_pop = 1'b1;
                        if (s_d.cplt != '0) s_d.cplt = s_d.cplt - 1'b1;
                    end
                end else begin
                    s_d.mfp = mreq;
                end
                // whole-FIFO flush request, refused during access
                if (fifo_flush_req && !wr_valid && !rd_en && track_en) s_d.ffp = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{wr: '0, cm: '0, rd: '0, st: '0, cplt: '0, ovr: 1'b0,
                     ffp: 1'b0, mfp: 1'b0, rv: 1'b0, rdat: '0, ph: WP_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid        = s_q.rv;
    assign rd_data         = s_q.rdat;
    assign fifo_flush_busy = s_q.ffp;
    assign msg_flush_busy  = s_q.mfp;
    assign empty           = empty_w;
    assign full            = full_w;
    assign almost_full     = (used >= PW'(THR));
    assign overrun         = s_q.ovr;
    assign msg_avail       = (s_q.cplt != '0);

    // R8: occupancy never exceeds the array
    a_r8_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
        used <= PW'(DEPTH));
    // R4: a complete packet implies readable data
    a_r4_avail_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        msg_avail |-> !empty);
    // R13: overrun only falls through a flush
    a_r13_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !fifo_flush_busy) |=> overrun);
    // R10: the flush cycle leaves an empty, clean FIFO
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fifo_flush_busy) |=> (empty && !overrun && !msg_avail && !fifo_flush_busy));
    // R11: a request that collides with an access is not taken
    a_r11_flush_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fifo_flush_busy && fifo_flush_req && (wr_valid || rd_en)) |=> !fifo_flush_busy);
    // R1: nothing is read while the enable pipeline is low
    a_r1_off_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !rd_valid);
    // R12: a pending message flush retires in the first idle cycle
    a_r12_msg_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fifo_flush_busy && msg_flush_busy && !msg_flush_req &&
         !wr_valid && !rd_en && !wr_abort) |=> !msg_flush_busy);

endmodule

// File: tb/anc_pkt_fifo_test.sv
module anc_pkt_fifo_test;
    localparam int DEPTH = 256;
    localparam int DW    = 10;
    localparam int PW    = 9;
    localparam int THR   = 231;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, fifo_clk_en, track_en;
    logic          wr_valid, wr_sop, wr_eop, wr_abort;
    logic [PW-1:0] wr_len;
    logic [DW-1:0] wr_data;
    logic          rd_en, rd_valid;
    logic [DW-1:0] rd_data;
    logic          fifo_flush_req, msg_flush_req, fifo_flush_busy, msg_flush_busy;
    logic          empty, full, almost_full, overrun, msg_avail;

    anc_pkt_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_clk_en(fifo_clk_en), .track_en(track_en),
        .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_abort(wr_abort),
        .wr_len(wr_len), .wr_data(wr_data), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .fifo_flush_req(fifo_flush_req), .msg_flush_req(msg_flush_req),
        .fifo_flush_busy(fifo_flush_busy), .msg_flush_busy(msg_flush_busy),
        .empty(empty), .full(full), .almost_full(almost_full), .overrun(overrun),
        .msg_avail(msg_avail)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [DW:0] mq[$];
    logic [DW:0] oq[$];
    int   ph, mcplt, mtab;
    bit   movr, mffp, mmfp, exp_rv;
    bit [2:0] msh;
    logic [DW-1:0] exp_rd;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_used();
        return mq.size() + oq.size();
    endfunction

    task automatic model_clear();
        mq.delete(); oq.delete();
        ph = 0; mcplt = 0; mtab = 0; movr = 0; mffp = 0; mmfp = 0;
    endtask

    task automatic step_model();
        bit act = msh[2];
        int used0 = m_used();
        int tab0 = mtab;
        bit wr_ok = 0;
        logic [DW:0] w;
        exp_rv = 0;
        if (act) begin
            if (mffp) begin
                model_clear();
            end else begin
                if (rd_en && mq.size() > 0) begin
                    w = mq.pop_front();
                    exp_rv = 1; exp_rd = w[DW-1:0];
                    if (w[DW]) begin
                        if (mcplt > 0) mcplt--;
                        if (track_en && mtab > 0) mtab--;
                    end
                end
                if (wr_abort) begin
                    oq.delete(); ph = 0;
                end else if (wr_valid) begin
                    if (wr_sop) begin
                        int bu = used0 - oq.size();
                        oq.delete();
                        if (track_en && (tab0 >= 8 || int'(wr_len) > DEPTH - bu)) begin
                            movr = 1; ph = wr_eop ? 0 : 2;
                        end else begin
                            ph = 1;
                            if (bu < DEPTH) begin oq.push_back({wr_eop, wr_data}); wr_ok = 1; end
                            else movr = 1;
                        end
                    end else if (ph == 1) begin
                        if (used0 < DEPTH) begin oq.push_back({wr_eop, wr_data}); wr_ok = 1; end
                        else movr = 1;
                    end else if (wr_eop) ph = 0;
                    if (ph == 1 && wr_eop) begin
                        foreach (oq[i]) mq.push_back(oq[i]);
                        oq.delete();
                        if (wr_ok) mcplt++;
                        if (track_en) mtab++;
                        ph = 0;
                    end
                end
                if ((mmfp || msg_flush_req) && !wr_valid && !rd_en && !wr_abort) begin
                    mmfp = 0;
                    if (track_en && tab0 > 0) begin
                        while (mq.size() > 0) begin
                            w = mq.pop_front();
                            if (w[DW]) break;
                        end
                        if (mcplt > 0) mcplt--;
                        mtab--;
                    end
                end else mmfp = mmfp || msg_flush_req;
                if (fifo_flush_req && !wr_valid && !rd_en && track_en) mffp = 1;
            end
        end
        msh = {msh[1:0], fifo_clk_en};
    endtask

    task automatic compare();
        check("R3 empty", empty, mq.size() == 0);
        check("R8 full", full, m_used() == DEPTH);
        check("R8 almost_full", almost_full, m_used() >= THR);
        check("R4 msg_avail", msg_avail, mcplt > 0);
        check("R13 overrun", overrun, movr);
        check("R10 fifo_flush_busy", fifo_flush_busy, mffp);
        check("R12 msg_flush_busy", msg_flush_busy, mmfp);
        check("R2 rd_valid", rd_valid, exp_rv);
        if (exp_rv) check("R2 rd_data", rd_data, exp_rd);
    endtask

    task automatic cyc();
        step_model();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle_in();
        wr_valid = 0; wr_sop = 0; wr_eop = 0; wr_abort = 0; wr_len = '0; wr_data = '0;
        rd_en = 0; fifo_flush_req = 0; msg_flush_req = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; fifo_clk_en = 0; idle_in();
        repeat (3) @(negedge clk);
        model_clear(); msh = '0; exp_rv = 0;
        rst_n = 1;
        compare();
    endtask

    task automatic enable_up();
        fifo_clk_en = 1;
        repeat (3) cyc();
    endtask

    task automatic send_pkt(input int len, input int abort_at, input int rdp, input int mfp_pct);
        for (int i = 0; i < len; i++) begin
            if (i == abort_at) begin
                wr_valid = 0; wr_sop = 0; wr_eop = 0; wr_abort = 1;
                rd_en = ($urandom % 100) < rdp;
                cyc();
                wr_abort = 0; rd_en = 0;
                return;
            end
            wr_valid = 1; wr_sop = (i == 0); wr_eop = (i == len - 1);
            wr_len = PW'(len); wr_data = DW'($urandom);
            rd_en = ($urandom % 100) < rdp;
            msg_flush_req = ($urandom % 100) < mfp_pct;
            cyc();
        end
        idle_in();
    endtask

    task automatic gap(input int n, input int rdp, input int mfp_pct);
        for (int i = 0; i < n; i++) begin
            rd_en = ($urandom % 100) < rdp;
            msg_flush_req = ($urandom % 100) < mfp_pct;
            cyc();
        end
        idle_in();
    endtask

    task automatic drain(output int n);
        n = 0;
        while (mq.size() > 0) begin
            rd_en = 1;
            cyc();
            if (rd_valid) n++;
        end
        rd_en = 0;
        cyc();
    endtask

    task automatic random_run(input int pkts);
        for (int p = 0; p < pkts; p++) begin
            int len = 1 + ($urandom % 24);
            int ab = (($urandom % 8) == 0) ? int'($urandom % len) : -1;
            send_pkt(len, ab, 55, 2);
            gap($urandom % 4, 60, 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd7711));
        track_en = 1;
        do_reset();
        check("R1 reset empty", empty, 1);
        check("R13 reset overrun", overrun, 0);

        // R1: writes during the enable fill are ignored
        fifo_clk_en = 1;
        for (int i = 0; i < 3; i++) begin
            wr_valid = 1; wr_sop = 1; wr_eop = 1; wr_len = 1; wr_data = DW'(i + 5);
            cyc();
        end
        check("R1 writes ignored while enable fills", empty, 1);
        wr_data = 10'h2A5;
        cyc();
        idle_in();
        check("R1 write taken after third cycle", empty, 0);
        drain(n);
        check("R1 one word stored", n, 1);

        // random mix, tracking on
        random_run(150);
        drain(n);

        // R11 / R10
        fifo_flush_req = 1; rd_en = 1; cyc(); idle_in();
        check("R11 flush refused during read", fifo_flush_busy, 0);
        fifo_flush_req = 1; track_en = 0; cyc(); idle_in(); track_en = 1;
        check("R11 flush refused with tracking off", fifo_flush_busy, 0);
        fifo_flush_req = 1; cyc(); idle_in();
        check("R10 flush busy for one cycle", fifo_flush_busy, 1);
        cyc();
        check("R10 flush done", fifo_flush_busy, 0);
        check("R10 flush leaves empty", empty, 1);
        check("R10 flush clears overrun", overrun, 0);

        // R5: length check against free space
        for (int p = 0; p < 7; p++) send_pkt(30, -1, 0, 0);
        send_pkt(50, -1, 0, 0);
        check("R5 oversized packet sets overrun", overrun, 1);
        check("R5 fill unchanged by refused packet", almost_full, 0);
        drain(n);
        check("R5 nothing of refused packet stored", n, 210);

        // R6: slot limit
        fifo_flush_req = 1; cyc(); idle_in(); cyc();
        for (int p = 0; p < 8; p++) send_pkt(30, -1, 0, 0);
        check("R8 warning at 240 words", almost_full, 1);
        check("R8 not full at 240 words", full, 0);
        send_pkt(2, -1, 0, 0);
        check("R6 ninth packet refused", overrun, 1);

        // R12: deferred then executed message flush
        wr_valid = 1; wr_sop = 1; wr_eop = 0; wr_len = 3; wr_data = 1; msg_flush_req = 1;
        cyc(); msg_flush_req = 0; wr_valid = 0; wr_sop = 0;
        check("R12 flush waits during write", msg_flush_busy, 1);
        cyc();
        check("R12 flush clears itself", msg_flush_busy, 0);
        wr_abort = 1; cyc(); idle_in();
        drain(n);
        check("R12 oldest packet removed", n, 210);

        // R9: abort frees the space of an open packet
        wr_valid = 1; wr_len = 240;
        for (int i = 0; i < 231; i++) begin
            wr_sop = (i == 0); wr_data = DW'(i); cyc();
        end
        idle_in();
        check("R9 open packet counts toward fill", almost_full, 1);
        check("R3 open packet not readable", empty, 1);
        wr_abort = 1; cyc(); idle_in();
        check("R9 abort returns space", almost_full, 0);
        send_pkt(2, -1, 0, 0);
        drain(n);
        check("R9 only the new packet remains", n, 2);

        // R7: tracking off
        track_en = 0;
        do_reset();
        enable_up();
        for (int p = 0; p < 12; p++) send_pkt(3, -1, 0, 0);
        check("R7 twelve packets available", msg_avail, 1);
        drain(n);
        check("R7 all twelve packets kept", n, 36);
        send_pkt(300, -1, 0, 0);
        check("R7 full after overlong packet", full, 1);
        check("R7 dropped words set overrun", overrun, 1);
        gap(5, 0, 0);
        check("R13 overrun holds", overrun, 1);
        drain(n);
        check("R7 array capacity kept", n, DEPTH);

        random_run(120);
        drain(n);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule